// File: doc/BRIEF.md
# Three-Wire Configuration Register Port

This block receives control settings over a write-only serial port and holds them in a small register file. The port has three wires: a serial data line, a shift clock and a write strobe. A frame of 13 bits is shifted in, most significant bit first. The frame carries a 3-bit address followed by a 10-bit data word. A rising edge on the write strobe then commits that word to the addressed register. The register contents drive parallel outputs for the rest of the chip. The register file holds one 8-bit configuration register, three 10-bit offset registers and three 6-bit gain registers, one of each kind per colour channel. One address is reserved.

All three serial wires are treated as asynchronous. Each is brought through a synchronizer into the system clock domain and edge-detected there. The shift clock must therefore be slower than the system clock: each phase must last at least three system clock cycles. Every accepted write raises a one-cycle completion pulse.

The block also decodes the pins that choose between serial and parallel register access. One output says when parallel access is permitted. A second output flags the forbidden pin combination.

Top module: `cfgp_serial_port`

## Requirements
- R1: Serial bits are sampled on rising edges of `ser_clk`. The first three bits form the address, most significant bit first. The next ten bits form the data word, bit 9 first and bit 0 last.
- R2: A rising edge of `ser_wr` that follows exactly 13 `ser_clk` rising edges commits the data word to the addressed register. The value appears on the outputs within five `clk` cycles of the strobe edge.
- R3: The address map is as follows. Address 0 is the configuration register (`cfg_word`). Addresses 1, 2 and 3 are the red, green and blue offsets. Their values appear on `offs` bits [9:0], [19:10] and [29:20]. Addresses 4, 5 and 6 are the red, green and blue gains. Their values appear on `gains` bits [5:0], [11:6] and [17:12]. A write changes only the register it addresses.
- R4: A gain write keeps data bits [5:0]. A configuration write keeps data bits [7:0]. The discarded upper bits have no effect.
- R5: If the strobe follows any number of shift clocks other than 13 (including none or 14), the frame is dropped. No register changes and no completion pulse is raised. Every strobe edge restarts the bit count, so the next frame is received normally.
- R6: A write to address 7 is ignored. No register changes and no completion pulse is raised.
- R7: While `rst_n` is low, every register reads zero. This also holds for a reset asserted after writes.
- R8: `wr_done` is high for exactly one `clk` cycle for each accepted write.
- R9: While `par_sel` is high, serial frames are not committed.
- R10: `par_access_ok` is high exactly when `oe_n` is high, `par_sel` is high and configuration bit 7 is 0. Configuration bit 7 set to 1 selects demultiplexed output, and parallel access is blocked in that mode.
- R11: `mode_fault` is high exactly when `oe_n` is low and `par_sel` is high, which is the prohibited pin combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data line |
| ser_wr | input | 1 | Write strobe; the rising edge commits the frame |
| par_sel | input | 1 | Access select: 1 = parallel, 0 = serial |
| oe_n | input | 1 | Sample output enable, active low |
| cfg_word | output | 8 | Configuration register |
| offs | output | 30 | Red, green and blue offset registers, red in the low bits |
| gains | output | 18 | Red, green and blue gain registers, red in the low bits |
| wr_done | output | 1 | One-cycle pulse per accepted write |
| par_access_ok | output | 1 | Parallel register access is permitted |
| mode_fault | output | 1 | Prohibited enable/select combination |

## Verification
The assertions check on every cycle that:
- reset clears the register file;
- no register moves unless a completion pulse is present;
- a single write never moves two registers;
- the completion pulse never lasts two cycles;
- no commit lands while parallel select is high;
- parallel permission never coincides with the fault flag or with demultiplexed output.

The bench scenarios are needed to show other properties. These are the bit order within a frame, the address decode, and the truncation to 6 and 8 bits. They also cover dropping frames that are too short or too long, and the counter restart after a dropped frame. The bench sweeps all eight addresses with asymmetric data patterns, and compares the results against a model of the register map.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 10;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CFG_W   = 8;
  localparam int OFF_W   = 10;
  localparam int GAIN_W  = 6;
  localparam int NCH     = 3;
  localparam int DEMUX_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG    = 3'd0,
    A_OFF_R  = 3'd1,
    A_OFF_G  = 3'd2,
    A_OFF_B  = 3'd3,
    A_GAIN_R = 3'd4,
    A_GAIN_G = 3'd5,
    A_GAIN_B = 3'd6,
    A_RSVD   = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/cfgp_sync_edge.sv
module cfgp_sync_edge #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] q_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      q_d <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      q_d <= stg[STAGES-1];
    end
  end

  assign q    = stg[STAGES-1];
  assign rise = q & ~q_d;
endmodule

// File: rtl/cfgp_frame_shifter.sv
module cfgp_frame_shifter
  import cfgp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   shift_en,
  input  logic   bit_in,
  input  logic   commit_req,
  input  logic   block,
  output frame_t frame_o,
  output logic   frame_vld
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      cnt       <= '0;
      frame_o   <= '0;
      frame_vld <= 1'b0;
    end else begin
      frame_vld <= 1'b0;
      if (commit_req) begin
        frame_vld <= (cnt == CNT_FULL) && !block;
        frame_o   <= frame_t'(sh);
        cnt       <= '0;
      end else if (shift_en) begin
        sh <= {sh[FRAME_W-2:0], bit_in};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgp_reg_bank.sv
module cfgp_reg_bank
  import cfgp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  frame_t                  wr_frame,
  input  logic                    wr_vld,
  output logic [CFG_W-1:0]        cfg_q,
  output logic [NCH*OFF_W-1:0]    off_q,
  output logic [NCH*GAIN_W-1:0]   gain_q,
  output logic                    wr_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      wr_done <= 1'b0;
    end else begin
      wr_done <= wr_vld && (wr_frame.addr != A_RSVD);
      if (wr_vld && wr_frame.addr == A_CFG) cfg_q <= wr_frame.data[CFG_W-1:0];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    localparam logic [ADDR_W-1:0] OFF_ADDR  = ADDR_W'(int'(A_OFF_R) + ch);
    localparam logic [ADDR_W-1:0] GAIN_ADDR = ADDR_W'(int'(A_GAIN_R) + ch);
    logic [OFF_W-1:0]  off_r;
    logic [GAIN_W-1:0] gain_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_r  <= '0;
        gain_r <= '0;
      end else if (wr_vld) begin
        if (wr_frame.addr == OFF_ADDR)  off_r  <= wr_frame.data[OFF_W-1:0];
        if (wr_frame.addr == GAIN_ADDR) gain_r <= wr_frame.data[GAIN_W-1:0];
      end
    end

    assign off_q[ch*OFF_W +: OFF_W]    = off_r;
    assign gain_q[ch*GAIN_W +: GAIN_W] = gain_r;
  end
endmodule

// File: rtl/cfgp_serial_port.sv
module cfgp_serial_port
  import cfgp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_clk,
  input  logic                  ser_data,
  input  logic                  ser_wr,
  input  logic                  par_sel,
  input  logic                  oe_n,
  output logic [CFG_W-1:0]      cfg_word,
  output logic [NCH*OFF_W-1:0]  offs,
  output logic [NCH*GAIN_W-1:0] gains,
  output logic                  wr_done,
  output logic                  par_access_ok,
  output logic                  mode_fault
);
  localparam int IDX_CLK  = 0;
  localparam int IDX_DATA = 1;
  localparam int IDX_WR   = 2;

  logic [2:0] pin_lvl, pin_rise;
  frame_t     frame;
  logic       frame_vld;
  logic       unused_sync;

  cfgp_sync_edge #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ser_wr, ser_data, ser_clk}),
    .q    (pin_lvl),
    .rise (pin_rise)
  );
  assign unused_sync = ^{pin_lvl[IDX_CLK], pin_lvl[IDX_WR], pin_rise[IDX_DATA]};

  cfgp_frame_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (pin_rise[IDX_CLK]),
    .bit_in    (pin_lvl[IDX_DATA]),
    .commit_req(pin_rise[IDX_WR]),
    .block     (par_sel),
    .frame_o   (frame),
    .frame_vld (frame_vld)
  );

  cfgp_reg_bank u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_frame(frame),
    .wr_vld  (frame_vld),
    .cfg_q   (cfg_word),
    .off_q   (offs),
    .gain_q  (gains),
    .wr_done (wr_done)
  );

  assign par_access_ok = oe_n && par_sel && !cfg_word[DEMUX_BIT];
  assign mode_fault    = !oe_n && par_sel;
endmodule

// File: rtl/cfgp_serial_port_chk.sv
module cfgp_serial_port_chk
  import cfgp_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [CFG_W-1:0]      cfg_word,
  input logic [NCH*OFF_W-1:0]  offs,
  input logic [NCH*GAIN_W-1:0] gains,
  input logic                  wr_done,
  input logic                  par_sel,
  input logic                  par_access_ok,
  input logic                  mode_fault
);
  p_reset_clears_r7: assert property (@(posedge clk)
    !rst_n |=> (cfg_word == '0 && offs == '0 && gains == '0));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_done |-> ($stable(cfg_word) && $stable(offs) && $stable(gains)));

  p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> $countones({cfg_word != $past(cfg_word),
                            offs[9:0]   != $past(offs[9:0]),
                            offs[19:10] != $past(offs[19:10]),
                            offs[29:20] != $past(offs[29:20]),
                            gains[5:0]   != $past(gains[5:0]),
                            gains[11:6]  != $past(gains[11:6]),
                            gains[17:12] != $past(gains[17:12])}) <= 1);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  p_no_commit_parallel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> !par_sel);

  p_par_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    par_access_ok |-> (!mode_fault && !cfg_word[DEMUX_BIT]));
endmodule

bind cfgp_serial_port cfgp_serial_port_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_word     (cfg_word),
  .offs         (offs),
  .gains        (gains),
  .wr_done      (wr_done),
  .par_sel      (par_sel),
  .par_access_ok(par_access_ok),
  .mode_fault   (mode_fault)
);

// File: tb/cfgp_serial_port_test.sv
module cfgp_serial_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_wr = 1'b0;
  logic par_sel = 1'b0, oe_n = 1'b0;
  logic [7:0]  cfg_word;
  logic [29:0] offs;
  logic [17:0] gains;
  logic wr_done, par_access_ok, mode_fault;

  int vectors = 0;
  int fails = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  logic [7:0] m_cfg;
  logic [9:0] m_off [3];
  logic [5:0] m_gain [3];
  int m_done;

  cfgp_serial_port uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_wr(ser_wr), .par_sel(par_sel), .oe_n(oe_n), .cfg_word(cfg_word),
    .offs(offs), .gains(gains), .wr_done(wr_done),
    .par_access_ok(par_access_ok), .mode_fault(mode_fault)
  );

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n && wr_done === 1'b1) done_cnt <= done_cnt + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " cfg"}, 32'(cfg_word), 32'(m_cfg));
    for (int c = 0; c < 3; c++) begin
      chk({tag, " off"}, 32'(offs[c*10 +: 10]), 32'(m_off[c]));
      chk({tag, " gain"}, 32'(gains[c*6 +: 6]), 32'(m_gain[c]));
    end
    chk({tag, " done count R8"}, 32'(done_cnt), 32'(m_done));
  endtask

  task automatic clear_model();
    m_cfg = '0;
    for (int c = 0; c < 3; c++) begin m_off[c] = '0; m_gain[c] = '0; end
  endtask

  // R1: MSB first, sampled at ser_clk rising edge
  task automatic send_bits(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i];
      #16 ser_clk = 1'b1;
      #32 ser_clk = 1'b0;
      #16;
    end
  endtask

  task automatic strobe();
    #16 ser_wr = 1'b1;
    #32 ser_wr = 1'b0;
    #64;
  endtask

  // R2 R3 R4 R6: expected effect of an accepted frame
  task automatic model_write(input logic [2:0] a, input logic [9:0] d);
    case (a)
      3'd0: begin m_cfg = d[7:0]; m_done++; end
      3'd1, 3'd2, 3'd3: begin m_off[a-1] = d; m_done++; end
      3'd4, 3'd5, 3'd6: begin m_gain[a-4] = d[5:0]; m_done++; end
      default: ;
    endcase
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [9:0] d);
    send_bits({3'b000, a, d}, 13);
    strobe();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [9:0] pats [6];
    pats[0] = 10'h3FF; pats[1] = 10'h000; pats[2] = 10'h2AA;
    pats[3] = 10'h155; pats[4] = 10'h001; pats[5] = 10'h200;
    clear_model();
    m_done = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_regs("R7 reset");
    chk("R8 idle", 32'(wr_done), 0);
    rst_n = 1'b1;
    #32;

    // R1 R2 R3 R4 R6: every address, every pattern
    for (int a = 0; a < 8; a++) begin
      for (int p = 0; p < 6; p++) begin
        logic [9:0] d;
        d = pats[p] ^ 10'(a * 37);
        write_reg(3'(a), d);
        model_write(3'(a), d);
        check_regs(a == 7 ? "R6 reserved" : "R3 map");
      end
    end

    // R5: wrong lengths dropped, counter restarts
    send_bits(16'h0DEF, 12); strobe(); check_regs("R5 short");
    send_bits({2'b00, 1'b1, 3'd1, 10'h123}, 14); strobe(); check_regs("R5 long");
    strobe(); check_regs("R5 empty");
    write_reg(3'd2, 10'h0F0); model_write(3'd2, 10'h0F0); check_regs("R5 restart");

    // R9: parallel select blocks serial commit
    par_sel = 1'b1; oe_n = 1'b1;
    write_reg(3'd5, 10'h02D);
    check_regs("R9 blocked");
    par_sel = 1'b0; oe_n = 1'b0;
    #32;

    // R10 R11: access mode decode
    for (int m = 0; m < 2; m++) begin
      write_reg(3'd0, 10'(m << 7));
      model_write(3'd0, 10'(m << 7));
      check_regs("R10 cfg");
      for (int k = 0; k < 4; k++) begin
        oe_n = k[0]; par_sel = k[1];
        #16;
        chk("R10 par_access_ok", 32'(par_access_ok), 32'(k[0] && k[1] && m == 0));
        chk("R11 mode_fault", 32'(mode_fault), 32'(!k[0] && k[1]));
      end
      par_sel = 1'b0; oe_n = 1'b0;
      #32;
    end

    // R7: reset after writes
    rst_n = 1'b0;
    #16;
    clear_model();
    check_regs("R7 late reset");
    rst_n = 1'b1;
    #32;
    write_reg(3'd6, 10'h3C7); model_write(3'd6, 10'h3C7); check_regs("R4 after reset");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule